// File: doc/BRIEF.md
# Power-fail write-protect reset controller

This block sits between a processor bus and a battery-backed static memory array and keeps the array safe while the main supply is unstable. Three digitised comparator flags report whether the supply is in tolerance, below the write-protect point and below the battery switchover point. Each flag passes through a two-stage synchroniser before it is used.

While the supply is good, the bus strobes pass straight through. A write strobe is raised while chip enable and write enable are both low. A data-output enable is raised while chip enable and output enable are low and write enable is high. A write-protect fault, or a reset that is still being held, forces both strobes off at once, even in the middle of a write.

The block also chooses the battery or the external supply for the array. It drives an open-drain style reset, modelled as an active-low pull-down enable. After each return to tolerance, the reset is held for a programmable number of clock cycles; 200 ms at the default clock.

Top module: `pfail_guard`

## Requirements
- R1: `wr_stb` is high exactly while `ce_n` and `we_n` are both low and access is allowed. It therefore rises on the later of the two falling edges and drops on the earlier rising edge, with no clock delay.
- R2: `dout_en` is high exactly while `ce_n` and `oe_n` are low, `we_n` is high and access is allowed. Pulling `we_n` low turns it off in the same cycle.
- R3: After the second rising clock edge that samples `vwp_raw` high, `wr_stb` and `dout_en` stay low for every combination of `ce_n`, `we_n` and `oe_n`. Access returns on the second edge that samples `vwp_raw` low.
- R4: `batt_sel` (1 = battery, 0 = external supply) follows `vsw_raw` with two clock edges of delay.
- R5: `rst_pd_n` is low whenever the synchronised in-tolerance flag is low. It falls on the third rising edge that samples `vok_raw` low.
- R6: `rst_pd_n` rises on edge number `HOLD_CYC + 2`, counted from the first rising edge that samples `vok_raw` high, and not before.
- R7: While `rst_pd_n` is low, `wr_stb` and `dout_en` stay low whatever the bus inputs are.
- R8: If the supply leaves tolerance during the hold period, the hold count restarts. The full `HOLD_CYC + 2` edges are counted again from the next return to tolerance.
- R9: While `rst_n` is low, `rst_pd_n` is 0, `batt_sel` is 1, and `wr_stb` and `dout_en` are 0.
- R10: A write already in progress is cut off on the second rising edge that samples `vwp_raw` high, with `ce_n` and `we_n` still low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vok_raw | input | 1 | Comparator: supply in tolerance (asynchronous) |
| vwp_raw | input | 1 | Comparator: supply below write-protect point (asynchronous) |
| vsw_raw | input | 1 | Comparator: supply below switchover point (asynchronous) |
| ce_n | input | 1 | Bus chip enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| oe_n | input | 1 | Bus output enable, active low |
| wr_stb | output | 1 | Gated write strobe to the array, active high |
| dout_en | output | 1 | Data output driver enable, active high |
| batt_sel | output | 1 | Array supply select: 1 battery, 0 external |
| rst_pd_n | output | 1 | Reset pull-down enable, low pulls the reset line down |

## Verification
All eight combinations of the three bus enables are applied in three states: normal operation, active write-protect, and the reset hold. This separates the exact decode of the write and read conditions from the blanket block applied during faults. Staggered falling and rising edges of chip enable and write enable show whether the write window opens at the later fall and closes at the earlier rise. Edge-by-edge sampling around each flag change pins down the synchroniser latency and the exact hold length. A supply dip in the middle of the hold period tells a counter that restarts apart from one that only pauses.

// File: rtl/pfail_pkg.sv
package pfail_pkg;

  // Synchronised comparator flags
  typedef struct packed {
    logic sw;   // below switchover point
    logic wp;   // below write-protect point
    logic ok;   // in tolerance
  } supply_flags_t;

  localparam int NUM_FLAGS = $bits(supply_flags_t);

  // Safe state: battery selected, protected, not in tolerance
  localparam supply_flags_t FLAGS_SAFE = '{sw: 1'b1, wp: 1'b1, ok: 1'b0};

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int             WIDTH   = 1,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d_async;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int HOLD_CYC = 200_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic released
);

  localparam int               CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rel_q, rel_d;
  logic             cnt_en;

  // Counting only while in tolerance and not yet released
  assign cnt_en = supply_ok && !rel_q;

  always_comb begin
    cnt_d = cnt_q;
    rel_d = rel_q;
    if (!supply_ok) begin
      cnt_d = '0;
      rel_d = 1'b0;
    end else if (cnt_en) begin
      if (cnt_q == LAST) rel_d = 1'b1;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
    end
  end

  assign released = rel_q;

endmodule

// File: rtl/bus_gate.sv
module bus_gate (
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic allow,
  output logic wr_stb,
  output logic dout_en
);

  logic sel, wr_req, rd_req;

  always_comb begin
    sel     = !ce_n;
    wr_req  = sel && !we_n;
    rd_req  = sel && !oe_n && we_n;
    wr_stb  = allow && wr_req;
    dout_en = allow && rd_req;
  end

endmodule

// File: rtl/pfail_guard.sv
module pfail_guard
  import pfail_pkg::*;
#(
  parameter int HOLD_CYC    = 200_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vok_raw,
  input  logic vwp_raw,
  input  logic vsw_raw,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_stb,
  output logic dout_en,
  output logic batt_sel,
  output logic rst_pd_n
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  supply_flags_t raw_flags, sync_flags;
  logic          hold_rel, access_ok;

  assign raw_flags = '{sw: vsw_raw, wp: vwp_raw, ok: vok_raw};

  flag_sync #(
    .WIDTH  (NUM_FLAGS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(FLAGS_SAFE)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .d_async(raw_flags),
    .q_sync (sync_flags)
  );

  hold_timer #(
    .HOLD_CYC(HOLD_CYC)
  ) u_hold (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .supply_ok(sync_flags.ok),
    .released (hold_rel)
  );

  assign access_ok = hold_rel && !sync_flags.wp;

  bus_gate u_gate (
    .ce_n   (ce_n),
    .we_n   (we_n),
    .oe_n   (oe_n),
    .allow  (access_ok),
    .wr_stb (wr_stb),
    .dout_en(dout_en)
  );

  assign batt_sel = sync_flags.sw;
  assign rst_pd_n = hold_rel;

endmodule

// File: rtl/pfail_guard_chk.sv
module pfail_guard_chk #(
  parameter int HOLD_CYC = 200_000
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic we_n,
  input logic oe_n,
  input logic wr_stb,
  input logic dout_en,
  input logic rst_pd_n,
  input logic ok_sync,
  input logic wp_sync
);

  localparam int              RUN_W   = $clog2(HOLD_CYC + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(HOLD_CYC);

  // Consecutive cycles with the synchronised in-tolerance flag high
  logic [RUN_W-1:0] ok_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ok_run <= '0;
    else if (!ok_sync)     ok_run <= '0;
    else if (ok_run != RUN_MAX) ok_run <= ok_run + 1'b1;
  end

  assert_wr_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (!ce_n && !we_n && rst_pd_n));

  assert_rd_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!ce_n && !oe_n && we_n && rst_pd_n));

  assert_no_contention_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && dout_en));

  assert_protect_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wp_sync |-> (!wr_stb && !dout_en));

  assert_fault_resets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_sync |=> !rst_pd_n);

  assert_hold_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pd_n) |-> (ok_run == RUN_MAX));

  assert_hold_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_pd_n |-> (!wr_stb && !dout_en));

endmodule

bind pfail_guard pfail_guard_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce_n    (ce_n),
  .we_n    (we_n),
  .oe_n    (oe_n),
  .wr_stb  (wr_stb),
  .dout_en (dout_en),
  .rst_pd_n(rst_pd_n),
  .ok_sync (sync_flags.ok),
  .wp_sync (sync_flags.wp)
);

// File: tb/sim_pfail_guard.sv
`timescale 1ns/1ps
module sim_pfail_guard;

  localparam int CLK_P = 10;
  localparam int HOLD  = 20;

  logic clk = 1'b0;
  logic rst_n, vok_raw, vwp_raw, vsw_raw, ce_n, we_n, oe_n;
  logic wr_stb, dout_en, batt_sel, rst_pd_n;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  pfail_guard #(.HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n),
    .vok_raw(vok_raw), .vwp_raw(vwp_raw), .vsw_raw(vsw_raw),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .wr_stb(wr_stb), .dout_en(dout_en), .batt_sel(batt_sel), .rst_pd_n(rst_pd_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // n rising edges, then stop at the following falling edge
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus(input logic [2:0] v);
    {ce_n, we_n, oe_n} = v;
    #1;
  endtask

  // Hold period check after vok_raw rises at the current falling edge
  task automatic hold_seq(input string req);
    for (int i = 1; i <= HOLD + 2; i++) begin
      step(1);
      if (i == HOLD + 1) chk(req, rst_pd_n, 1'b0);
      if (i == HOLD + 2) chk(req, rst_pd_n, 1'b1);
      if (i <= HOLD + 1) begin
        bus(3'b001);
        chk("R7 write blocked in hold", wr_stb, 1'b0);
        bus(3'b010);
        chk("R7 read blocked in hold", dout_en, 1'b0);
        bus(3'b111);
      end
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vok_raw = 1'b0; vwp_raw = 1'b1; vsw_raw = 1'b1;
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    step(3);
    // R9 reset state
    chk("R9 rst_pd_n", rst_pd_n, 1'b0);
    chk("R9 batt_sel", batt_sel, 1'b1);
    chk("R9 wr_stb",   wr_stb,   1'b0);
    chk("R9 dout_en",  dout_en,  1'b0);
    rst_n = 1'b1;
    step(4);

    // Supply comes up: R4 switchover timing and R6 hold length
    vok_raw = 1'b1; vwp_raw = 1'b0; vsw_raw = 1'b0;
    step(1);
    chk("R4 batt still selected", batt_sel, 1'b1);
    step(1);
    chk("R4 external selected", batt_sel, 1'b0);
    for (int i = 3; i <= HOLD + 2; i++) begin
      step(1);
      if (i == HOLD + 1) chk("R6 hold not yet over", rst_pd_n, 1'b0);
      if (i == HOLD + 2) chk("R6 reset released", rst_pd_n, 1'b1);
      if (i <= HOLD + 1) begin
        bus(3'b001);
        chk("R7 write blocked in hold", wr_stb, 1'b0);
        bus(3'b111);
      end
    end

    // R1/R2 sweep in normal operation
    for (int v = 0; v < 8; v++) begin
      bus(3'(v));
      chk("R1 sweep wr_stb", wr_stb, (v[2] == 1'b0) && (v[1] == 1'b0));
      chk("R2 sweep dout_en", dout_en, (v[2] == 1'b0) && (v[0] == 1'b0) && (v[1] == 1'b1));
      step(1);
    end

    // R1 edge ordering
    bus(3'b111);
    bus(3'b011); chk("R1 ce low only", wr_stb, 1'b0);
    bus(3'b001); chk("R1 later fall we", wr_stb, 1'b1);
    bus(3'b011); chk("R1 earlier rise we", wr_stb, 1'b0);
    bus(3'b101); chk("R1 we low only", wr_stb, 1'b0);
    bus(3'b001); chk("R1 later fall ce", wr_stb, 1'b1);
    bus(3'b101); chk("R1 earlier rise ce", wr_stb, 1'b0);

    // R2 write enable kills outputs
    bus(3'b010); chk("R2 read on", dout_en, 1'b1);
    bus(3'b000); chk("R2 we low drops outputs", dout_en, 1'b0);
    chk("R2 we low writes", wr_stb, 1'b1);

    // R10 write cut off by protect
    bus(3'b001);
    step(1);
    vwp_raw = 1'b1;
    step(1);
    chk("R10 write before sync", wr_stb, 1'b1);
    step(1);
    chk("R10 write cut off", wr_stb, 1'b0);

    // R3 sweep under protect
    for (int v = 0; v < 8; v++) begin
      bus(3'(v));
      chk("R3 protect wr_stb", wr_stb, 1'b0);
      chk("R3 protect dout_en", dout_en, 1'b0);
      step(1);
    end
    bus(3'b001);
    vwp_raw = 1'b0;
    step(1);
    chk("R3 still protected", wr_stb, 1'b0);
    step(1);
    chk("R3 access back", wr_stb, 1'b1);
    bus(3'b111);

    // R4 switchover to battery and back
    vsw_raw = 1'b1;
    step(1); chk("R4 before sync", batt_sel, 1'b0);
    step(1); chk("R4 battery", batt_sel, 1'b1);
    vsw_raw = 1'b0;
    step(2); chk("R4 external again", batt_sel, 1'b0);

    // R5 supply fault
    vok_raw = 1'b0;
    step(2); chk("R5 reset not yet", rst_pd_n, 1'b1);
    step(1); chk("R5 reset asserted", rst_pd_n, 1'b0);
    bus(3'b001); chk("R7 write blocked in fault", wr_stb, 1'b0);
    bus(3'b111);

    // R8 dip during hold restarts the count
    vok_raw = 1'b1;
    step(HOLD/2 + 2);
    chk("R8 mid hold", rst_pd_n, 1'b0);
    vok_raw = 1'b0;
    step(3);
    vok_raw = 1'b1;
    hold_seq("R8 hold restarted");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule